// File: doc/BRIEF.md
# Histogram-Driven Luma Curve Generator

This block turns a per-frame luminance histogram into a smoothed tone curve once per vertical sync. On a start pulse it walks 64 curve points. Each point is the running total of the histogram bins below it. That total is normalized against the frame's pixel count and clipped to an 8-bit value, so the result is a cumulative-distribution curve that runs from 0 to full scale.

Each curve point is also kept in a recursive filter state. A configurable shift sets the filter strength, so the curve follows scene changes gradually rather than jumping from frame to frame. When the last point is done, the filtered points are packed four to a word into sixteen 32-bit output words. All sixteen words are replaced together, in the cycle of a one-cycle done pulse.

A configuration load presets the filter states from a supplied initial curve. A reserved shift code, or a cleared enable, freezes the block so that the current curve stays in place. The normalization divide is sequential and handles one point at a time. A busy output marks a frame in progress.

Top module: `luma_curve_gen`

## Requirements
- R1: After reset, all output words are zero, and busy and done are low.
- R2: Curve point 0 is never modified by a frame update. It keeps its preset value, which is 0 after reset, and it appears in bits 7:0 of word 0.
- R3: For points i = 1..63, the target is (sum of bins 0..i-1) shifted left by (11 + pix_sum[31:30]), divided by pix_sum[29:0]. Bin 63 never affects any output.
- R4: A quotient of 255 or more gives a target of 255. Every later point in the same frame also gets 255.
- R5: Each frame updates the filter state of point i (i ≥ 1) as s = s - (s >> rt) + target.
- R6: Bits 8j+7:8j of output word k hold the filter state of point 4k+j shifted right by rt, truncated to 8 bits.
- R7: While cfg_rt = 7 or cfg_en = 0, a vsync pulse starts nothing: busy stays low, no done is produced and the words hold. A load is also ignored in this state.
- R8: A load while enabled, not frozen and idle presets each state to the initial point shifted left by rt. The words show the initial curve from the next cycle.
- R9: busy is high from the cycle after an accepted vsync pulse until the done cycle. A vsync pulse or a load that arrives while busy is ignored.
- R10: A pixel count of zero gives a target of 255 for every point.
- R11: The output words change only in the cycle done is high, or in the cycle after an accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hist_bins | input | 64*BIN_W | Histogram, bin b in bits b*BIN_W +: BIN_W |
| pix_sum | input | 32 | Pixel count in bits 29:0, extra shift in bits 31:30 |
| cfg_rt | input | 3 | Filter shift (0..6); 7 freezes the block |
| cfg_en | input | 1 | Enable; low freezes the block |
| init_load | input | 1 | One-cycle pulse that presets the filter states |
| init_curve | input | 512 | Initial curve, point p in bits 8p +: 8 |
| vs_start | input | 1 | Vertical sync pulse that starts a frame update |
| curve_words | output | 512 | Sixteen packed words, word k in bits 32k +: 32 |
| curve_done | output | 1 | One-cycle pulse when a new curve is published |
| busy | output | 1 | Frame update in progress |

## Verification
The two events that can fall in the same cycle are a frame in flight and a second control event: a new vsync pulse, or a curve load that arrives before the divider has finished all 63 points. The bench provokes this by pulsing vs_start and then, partway through the frame, pulsing vs_start and init_load together with a different initial curve. It passes only if exactly one done pulse occurs, the published words match the single-frame model with the load ignored, and busy stays low for thousands of cycles afterwards. A load issued together with the first vsync of an idle block is also legal: the preset lands first, and the frame then filters from the preset states.

// File: rtl/lc_pkg.sv
package lc_pkg;
    localparam int RT_W       = 3;
    localparam logic [RT_W-1:0] RT_FREEZE = '1;
    localparam int RT_MAX     = (1 << RT_W) - 2;
    localparam int STATE_W    = 8 + RT_MAX;
    localparam int BASE_SHIFT = 11;
    localparam int PIX_W      = 30;
    localparam int GAIN_W     = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_PACK
    } lc_state_e;

    typedef struct packed {
        logic       sat;
        logic [7:0] val;
    } lc_tgt_t;

    function automatic logic [4:0] lc_shamt(input logic [GAIN_W-1:0] g);
        return 5'(BASE_SHIFT) + 5'(g);
    endfunction
endpackage

// File: rtl/lc_divider.sv
module lc_divider #(
    parameter int DVD_W = 36,
    parameter int DVS_W = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             done,
    output logic [DVD_W-1:0] quot
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [DVD_W-1:0] q_q;
    logic [DVS_W:0]   rem_q, rem_sh, rem_nx;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q, done_q, ge;

    always_comb begin
        rem_sh = {rem_q[DVS_W-1:0], q_q[DVD_W-1]};
        ge     = rem_sh >= {1'b0, divisor};
        rem_nx = ge ? rem_sh - {1'b0, divisor} : rem_sh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q    <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                q_q   <= dividend;
                rem_q <= '0;
                cnt_q <= CNT_W'(DVD_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                q_q   <= {q_q[DVD_W-2:0], ge};
                rem_q <= rem_nx;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done = done_q;
    assign quot = q_q;
endmodule

// File: rtl/lc_filter_bank.sv
module lc_filter_bank import lc_pkg::*; #(
    parameter int WORDS = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   preset,
    input  logic [WORDS*32-1:0]    preset_pts,
    input  logic [RT_W-1:0]        rt,
    input  logic                   upd,
    input  logic [$clog2(WORDS*4)-1:0] upd_idx,
    input  logic [7:0]             upd_tgt,
    input  logic                   pack,
    output logic [WORDS*32-1:0]    words
);
    localparam int NPTS  = WORDS * 4;
    localparam int IDX_W = $clog2(NPTS);

    logic [STATE_W-1:0] st [NPTS];
    logic [7:0]         wb [NPTS];

    for (genvar p = 0; p < NPTS; p++) begin : g_pt
        localparam bit P_UPD = (p != 0);

        always_ff @(posedge clk) begin
            if (rst)
                st[p] <= '0;
            else if (preset)
                st[p] <= STATE_W'(preset_pts[8*p +: 8]) << rt;
            else if (P_UPD && upd && upd_idx == IDX_W'(p))
                st[p] <= st[p] - (st[p] >> rt) + STATE_W'(upd_tgt);
        end

        always_ff @(posedge clk) begin
            if (rst)
                wb[p] <= '0;
            else if (preset)
                wb[p] <= preset_pts[8*p +: 8];
            else if (pack)
                wb[p] <= 8'(st[p] >> rt);
        end

        assign words[8*p +: 8] = wb[p];
    end
endmodule

// File: rtl/luma_curve_gen.sv
module luma_curve_gen import lc_pkg::*; #(
    parameter int WORDS = 16,
    parameter int BIN_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [WORDS*4*BIN_W-1:0] hist_bins,
    input  logic [31:0]              pix_sum,
    input  logic [RT_W-1:0]          cfg_rt,
    input  logic                     cfg_en,
    input  logic                     init_load,
    input  logic [WORDS*32-1:0]      init_curve,
    input  logic                     vs_start,
    output logic [WORDS*32-1:0]      curve_words,
    output logic                     curve_done,
    output logic                     busy
);
    localparam int NPTS  = WORDS * 4;
    localparam int IDX_W = $clog2(NPTS);
    localparam int SUM_W = BIN_W + IDX_W;
    localparam int DVD_W = SUM_W + BASE_SHIFT + (1 << GAIN_W) - 1;

    lc_state_e        state_q;
    logic [IDX_W-1:0] idx_q;
    logic [SUM_W-1:0] sum_q;
    logic             sat_q, done_q;

    logic             active, preset, pack;
    logic             div_start, div_done, step, upd;
    logic [DVD_W-1:0] dividend, quot;
    logic [PIX_W-1:0] pix_cnt;
    logic [BIN_W-1:0] cur_bin;
    lc_tgt_t          tgt;

    assign active   = cfg_en && (cfg_rt != RT_FREEZE);
    assign pix_cnt  = pix_sum[PIX_W-1:0];
    assign dividend = DVD_W'(sum_q) << lc_shamt(pix_sum[31:30]);
    assign cur_bin  = hist_bins[idx_q*BIN_W +: BIN_W];
    assign preset   = init_load && active && (state_q == ST_IDLE);
    assign pack     = (state_q == ST_PACK);

    // Per-point target: short-cut to full scale, or wait on the divider.
    always_comb begin
        div_start = 1'b0;
        step      = 1'b0;
        tgt       = '{sat: 1'b0, val: 8'hFF};
        case (state_q)
            ST_ISSUE: begin
                if (sat_q || pix_cnt == '0)
                    step = 1'b1;
                else
                    div_start = 1'b1;
            end
            ST_WAIT: begin
                if (div_done) begin
                    step = 1'b1;
                    if ((|quot[DVD_W-1:8]) || (&quot[7:0]))
                        tgt.sat = 1'b1;
                    else
                        tgt.val = quot[7:0];
                end
            end
            default: ;
        endcase
        upd = step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            sum_q   <= '0;
            sat_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (vs_start && active) begin
                        state_q <= ST_ISSUE;
                        idx_q   <= IDX_W'(1);
                        sum_q   <= SUM_W'(hist_bins[0 +: BIN_W]);
                        sat_q   <= 1'b0;
                    end
                end
                ST_ISSUE: if (div_start) state_q <= ST_WAIT;
                ST_PACK: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: ;
            endcase
            if (step) begin
                if (tgt.sat) sat_q <= 1'b1;
                if (idx_q == IDX_W'(NPTS - 1)) begin
                    state_q <= ST_PACK;
                end else begin
                    idx_q   <= idx_q + 1'b1;
                    sum_q   <= sum_q + SUM_W'(cur_bin);
                    state_q <= ST_ISSUE;
                end
            end
        end
    end

    lc_divider #(.DVD_W(DVD_W), .DVS_W(PIX_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (dividend),
        .divisor  (pix_cnt),
        .done     (div_done),
        .quot     (quot)
    );

    lc_filter_bank #(.WORDS(WORDS)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .preset     (preset),
        .preset_pts (init_curve),
        .rt         (cfg_rt),
        .upd        (upd),
        .upd_idx    (idx_q),
        .upd_tgt    (tgt.val),
        .pack       (pack),
        .words      (curve_words)
    );

    assign curve_done = done_q;
    assign busy       = (state_q != ST_IDLE);
endmodule

// File: rtl/lc_checker.sv
module lc_checker import lc_pkg::*; #(
    parameter int WORDS = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                vs_start,
    input logic                cfg_en,
    input logic [RT_W-1:0]     cfg_rt,
    input logic                init_load,
    input logic                curve_done,
    input logic                busy,
    input logic [WORDS*32-1:0] curve_words
);
    // R9: a frame only starts from a vsync pulse
    assert_busy_from_vs_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(vs_start));

    // R9: done is published as the block returns to idle
    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        curve_done |-> !busy);

    // R9: done lasts a single cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        curve_done |=> !curve_done);

    // R7: a frozen block never starts
    assert_frozen_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && vs_start && (!cfg_en || cfg_rt == RT_FREEZE)) |=> !busy);

    // R11: words move only with done or right after a load
    assert_words_atomic_R11: assert property (@(posedge clk) disable iff (rst)
        (!curve_done && !$past(init_load)) |-> $stable(curve_words));
endmodule

bind luma_curve_gen lc_checker #(.WORDS(WORDS)) u_lc_chk (
    .clk         (clk),
    .rst         (rst),
    .vs_start    (vs_start),
    .cfg_en      (cfg_en),
    .cfg_rt      (cfg_rt),
    .init_load   (init_load),
    .curve_done  (curve_done),
    .busy        (busy),
    .curve_words (curve_words)
);

// File: tb/luma_curve_gen_bench.sv
module luma_curve_gen_bench;
    localparam int WORDS = 16;
    localparam int BIN_W = 16;
    localparam int NPTS  = WORDS * 4;

    typedef struct packed {
        logic [31:0] psum;
        logic [2:0]  rt;
        logic [7:0]  seed;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{32'd240000,                 3'd2, 8'd5},
        '{32'd240000,                 3'd2, 8'd11},
        '{32'h4000_0000 | 32'd480000, 3'd3, 8'd3},
        '{32'hC000_0000 | 32'd60000,  3'd1, 8'd9},
        '{32'd0,                      3'd0, 8'd2},
        '{32'd900000,                 3'd6, 8'd13}
    };

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic [NPTS*BIN_W-1:0]    hist_bins;
    logic [31:0]              pix_sum = '0;
    logic [2:0]               cfg_rt = 3'd2;
    logic                     cfg_en = 1'b1;
    logic                     init_load = 1'b0;
    logic [WORDS*32-1:0]      init_curve = '0;
    logic                     vs_start = 1'b0;
    logic [WORDS*32-1:0]      curve_words;
    logic                     curve_done;
    logic                     busy;

    int                       bin_arr [NPTS];
    longint unsigned          mst [NPTS];
    int                       n_chk = 0;
    int                       n_bad = 0;
    int                       done_cnt = 0;
    int                       busy_seen = 0;
    int                       cycles = 0;

    always #5 clk = ~clk;

    always_comb
        for (int i = 0; i < NPTS; i++) hist_bins[i*BIN_W +: BIN_W] = BIN_W'(bin_arr[i]);

    luma_curve_gen #(.WORDS(WORDS), .BIN_W(BIN_W)) u_luma_curve_gen (
        .clk(clk), .rst(rst), .hist_bins(hist_bins), .pix_sum(pix_sum),
        .cfg_rt(cfg_rt), .cfg_en(cfg_en), .init_load(init_load),
        .init_curve(init_curve), .vs_start(vs_start),
        .curve_words(curve_words), .curve_done(curve_done), .busy(busy)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (curve_done) done_cnt <= done_cnt + 1;
        if (busy) busy_seen <= busy_seen + 1;
        if (cycles > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL R9 watchdog expired act=%0d exp<=190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic fill_bins(input logic [7:0] seed);
        for (int i = 0; i < NPTS - 1; i++) bin_arr[i] = ((i * seed + 7) % 61) * 16;
        bin_arr[NPTS-1] = 16'hFFFF;  // R3: must never matter
    endtask

    task automatic model_frame(input logic [31:0] ps, input int rt);
        longint unsigned sum = 0, pix = 0, q = 0, t = 0;
        bit sat = 0;
        int sh;
        pix = ps[29:0];
        sh  = 11 + int'(ps[31:30]);
        for (int i = 1; i < NPTS; i++) begin
            sum += longint'(bin_arr[i-1]);
            if (sat || pix == 0) t = 255;
            else begin
                q = (sum << sh) / pix;
                if (q < 255) t = q;
                else begin t = 255; sat = 1; end
            end
            mst[i] = mst[i] - (mst[i] >> rt) + t;
        end
    endtask

    task automatic check_words(input string req, input int rt);
        for (int k = 0; k < WORDS; k++) begin
            logic [31:0] exp;
            for (int j = 0; j < 4; j++) exp[8*j +: 8] = 8'(mst[4*k+j] >> rt);
            check(curve_words[32*k +: 32] == exp, req, $sformatf("word %0d", k),
                  64'(curve_words[32*k +: 32]), 64'(exp));
        end
    endtask

    task automatic pulse_vs();
        @(negedge clk) vs_start = 1'b1;
        @(negedge clk) vs_start = 1'b0;
    endtask

    task automatic wait_done();
        while (!curve_done) @(negedge clk);
    endtask

    initial begin
        logic [WORDS*32-1:0] snap;
        int d0, b0;
        for (int i = 0; i < NPTS; i++) begin bin_arr[i] = 0; mst[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(curve_words == '0, "R1", "words after reset", 64'(curve_words[63:0]), 0);
        check(!busy && !curve_done, "R1", "busy/done after reset", {busy, curve_done}, 0);

        // R8 / R6: preset from initial curve
        for (int p = 0; p < NPTS; p++) init_curve[8*p +: 8] = 8'(p * 3 + 1);
        cfg_rt = 3'd2;
        init_load = 1'b1;
        @(negedge clk) init_load = 1'b0;
        for (int p = 0; p < NPTS; p++) mst[p] = longint'(p * 3 + 1) << 2;
        check_words("R8", 2);

        // Table walk: R3 R4 R5 R6 R10
        for (int v = 0; v < NVEC; v++) begin
            pix_sum = VECS[v].psum;
            cfg_rt  = VECS[v].rt;
            fill_bins(VECS[v].seed);
            pulse_vs();
            wait_done();
            model_frame(VECS[v].psum, int'(VECS[v].rt));
            check_words(v == 4 ? "R10" : (v == 3 ? "R4" : "R5"), int'(VECS[v].rt));
            if (v == 0)  // R2: point 0 keeps its preset value
                check(curve_words[7:0] == 8'd1, "R2", "point 0", 64'(curve_words[7:0]), 1);
            @(negedge clk);
        end

        // R7: freeze code ignores vsync and load
        cfg_rt = 3'd7;
        snap = curve_words;
        d0 = done_cnt; b0 = busy_seen;
        pulse_vs();
        init_load = 1'b1;
        @(negedge clk) init_load = 1'b0;
        repeat (100) @(negedge clk);
        check(curve_words == snap, "R7", "words frozen", 64'(curve_words[63:0]), 64'(snap[63:0]));
        check(done_cnt == d0 && busy_seen == b0, "R7", "no activity frozen",
              64'(done_cnt - d0), 0);

        // R7: enable low
        cfg_rt = 3'd2;
        cfg_en = 1'b0;
        pulse_vs();
        repeat (100) @(negedge clk);
        check(curve_words == snap, "R7", "words disabled", 64'(curve_words[63:0]), 64'(snap[63:0]));
        check(done_cnt == d0 && busy_seen == b0, "R7", "no activity disabled",
              64'(done_cnt - d0), 0);
        cfg_en = 1'b1;

        // R9: vsync and load while busy are ignored
        pix_sum = 32'd240000;
        fill_bins(8'd7);
        d0 = done_cnt;
        pulse_vs();
        repeat (50) @(negedge clk);
        check(busy, "R9", "busy mid frame", 64'(busy), 1);
        for (int p = 0; p < NPTS; p++) init_curve[8*p +: 8] = 8'hA5;
        vs_start = 1'b1; init_load = 1'b1;
        @(negedge clk) begin vs_start = 1'b0; init_load = 1'b0; end
        wait_done();
        model_frame(32'd240000, 2);
        check_words("R9", 2);
        @(negedge clk);
        snap = curve_words;
        repeat (3000) @(negedge clk);
        check(done_cnt == d0 + 1 && !busy, "R9", "single frame only",
              64'(done_cnt - d0), 1);
        check(curve_words == snap, "R11", "words hold after done",
              64'(curve_words[63:0]), 64'(snap[63:0]));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule